// File: doc/BRIEF.md
# SPI Slave Hold-Pause Front End

This block sits between the SPI slave pins and the slave's shifter and command logic. It watches chip select, the active-low pause input and the serial clock level. It decides when a transfer is paused, when it resumes, and when an abandoned pause must reset the command logic. The pins are oversampled in a fast system clock, so the slave runs entirely in that clock domain. The slave receives one-cycle SCK rising-edge and falling-edge enables from this block. It also receives a freeze flag and an output-enable for its serial data output.

The pause request is qualified by the SCK level, which suits both mode 0 and mode 3. A pause that is requested while SCK is high takes effect only once SCK is next low. A release that is requested while SCK is high also waits for SCK to go low. While the transfer is paused, the block withholds every clock-edge enable, so the shifter neither gains nor loses a bit across the pause. If chip select is raised during a pause, the block issues a one-cycle reset to the command logic. It then stays idle until chip select is low and the pause input is high together.

States: `ST_IDLE` (deselected), `ST_RUN` (selected, shifting), `ST_ENTER_WAIT` (pause requested while SCK high), `ST_PAUSED`, `ST_LEAVE_WAIT` (release requested while SCK high) and `ST_KILL` (one-cycle reset). Transitions:
- `ST_IDLE` goes to `ST_RUN` on select with pause high.
- `ST_RUN` goes to `ST_PAUSED` on pause with SCK low, and to `ST_ENTER_WAIT` on pause with SCK high.
- `ST_ENTER_WAIT` goes to `ST_PAUSED` when SCK goes low, and back to `ST_RUN` if the pause is withdrawn first.
- `ST_PAUSED` goes to `ST_RUN` on release with SCK low, and to `ST_LEAVE_WAIT` on release with SCK high.
- `ST_LEAVE_WAIT` goes to `ST_RUN` when SCK goes low, and back to `ST_PAUSED` if the pause is reasserted first.
- `ST_PAUSED` and `ST_LEAVE_WAIT` go to `ST_KILL` on deselect.
- `ST_KILL` goes to `ST_IDLE`.
- `ST_RUN` and `ST_ENTER_WAIT` go to `ST_IDLE` on deselect.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While chip select is high, a low pause input never asserts `frozen`.
- R2: With chip select low and SCK low, a falling pause input asserts `frozen` exactly three system clock edges after the pin changes.
- R3: A pause that arrives while SCK is high leaves `frozen` low until SCK goes low. `frozen` then asserts three edges after that SCK change.
- R4: A release with SCK low clears `frozen`. A release while SCK is high keeps `frozen` high until SCK goes low.
- R5: While `frozen` is high, `so_en` is 0, and SCK toggling produces no `sck_rise_en` or `sck_fall_en` pulse.
- R6: Raising chip select while paused produces exactly one `slave_rst` pulse of one cycle, and `frozen` clears.
- R7: After deselect, `so_en` rises only when chip select is low and the pause input is high. Selecting with pause low keeps `so_en` at 0 and passes no clock edges.
- R8: When running, each SCK rising pin edge yields one `sck_rise_en` pulse, and each falling pin edge yields one `sck_fall_en` pulse.
- R9: After reset, `frozen`, `so_en`, `slave_rst`, `sck_rise_en` and `sck_fall_en` are all 0.
- R10: Across a pause that was deferred because SCK was high, the falling SCK edge that starts the pause is delivered. Across a release that was deferred because SCK was high, the falling SCK edge that ends it is withheld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| hold_n_pin | input | 1 | Pause request pin, active low, asynchronous |
| frozen | output | 1 | Freeze flag for the bit counter and shift registers |
| so_en | output | 1 | Output-enable for serial data out; 0 means high impedance |
| slave_rst | output | 1 | One-cycle reset to the command logic |
| sck_rise_en | output | 1 | One-cycle enable per qualified SCK rising edge |
| sck_fall_en | output | 1 | One-cycle enable per qualified SCK falling edge |

## Verification
A pin change made between edges reaches the synchronized copy after two system clock edges. The edge enables are visible from then until the next edge, and `frozen`, `so_en` and `slave_rst` follow on the third edge. The bench drives pins one nanosecond after a rising edge and waits four edges before it samples state outputs. It counts enable and reset pulses at every rising edge, and compares the counts between phases. One check samples after exactly two and three edges to pin down the pause latency. A sweep over the SCK level at pause and at release covers the deferred and immediate paths in each combination.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUN        = 3'd1,
        ST_ENTER_WAIT = 3'd2,
        ST_PAUSED     = 3'd3,
        ST_LEAVE_WAIT = 3'd4,
        ST_KILL       = 3'd5
    } hold_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sck_edge_det.sv
module sck_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    output logic rise,
    output logic fall
);
    logic sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    input  logic rise,
    input  logic fall,
    output logic frozen,
    output logic so_en,
    output logic slave_rst,
    output logic rise_en,
    output logic fall_en
);
    hold_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (!cs_n_s && hold_n_s) nxt = ST_RUN;
            ST_RUN:
                if (cs_n_s)        nxt = ST_IDLE;
                else if (!hold_n_s) nxt = sck_s ? ST_ENTER_WAIT : ST_PAUSED;
            ST_ENTER_WAIT:
                if (cs_n_s)        nxt = ST_IDLE;
                else if (hold_n_s) nxt = ST_RUN;
                else if (!sck_s)   nxt = ST_PAUSED;
            ST_PAUSED:
                if (cs_n_s)        nxt = ST_KILL;
                else if (hold_n_s) nxt = sck_s ? ST_LEAVE_WAIT : ST_RUN;
            ST_LEAVE_WAIT:
                if (cs_n_s)         nxt = ST_KILL;
                else if (!hold_n_s) nxt = ST_PAUSED;
                else if (!sck_s)    nxt = ST_RUN;
            ST_KILL:
                nxt = ST_IDLE;
            default:
                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    logic passing;
    always_comb begin
        frozen    = 1'b0;
        so_en     = 1'b0;
        slave_rst = 1'b0;
        passing   = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_RUN:        begin so_en = 1'b1; passing = 1'b1; end
            ST_ENTER_WAIT: begin so_en = 1'b1; passing = 1'b1; end
            ST_PAUSED:     frozen = 1'b1;
            ST_LEAVE_WAIT: frozen = 1'b1;
            ST_KILL:       slave_rst = 1'b1;
            default:       ;
        endcase
        rise_en = rise & passing;
        fall_en = fall & passing;
    end

    a_r1_frozen_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !$past(cs_n_s));
    a_r3_enter_on_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> !$past(sck_s));
    a_r4_leave_on_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frozen) |-> (!$past(sck_s) || slave_rst));
    a_r5_quiet_while_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> (!so_en && !rise_en && !fall_en));
    a_r6_single_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slave_rst |=> (!slave_rst && !frozen));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic hold_n_pin,
    output logic frozen,
    output logic so_en,
    output logic slave_rst,
    output logic sck_rise_en,
    output logic sck_fall_en
);
    localparam int PINS = 3;
    localparam logic [PINS-1:0] PIN_IDLE = 3'b101;

    logic [PINS-1:0] pins_s;
    logic rise, fall;

    pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(PINS), .RST_VAL(PIN_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n_pin, sck_pin, hold_n_pin}),
        .q    (pins_s)
    );

    sck_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sck_s(pins_s[1]),
        .rise (rise),
        .fall (fall)
    );

    hold_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[2]),
        .sck_s    (pins_s[1]),
        .hold_n_s (pins_s[0]),
        .rise     (rise),
        .fall     (fall),
        .frozen   (frozen),
        .so_en    (so_en),
        .slave_rst(slave_rst),
        .rise_en  (sck_rise_en),
        .fall_en  (sck_fall_en)
    );
endmodule

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
    logic frozen, so_en, slave_rst, rise_en, fall_en;
    int checks = 0, errors = 0;
    int rc = 0, fc = 0, kc = 0;
    int r0, f0, k0;

    always #4 clk = ~clk;

    spi_hold_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .hold_n_pin(hold_n),
        .frozen(frozen), .so_en(so_en), .slave_rst(slave_rst),
        .sck_rise_en(rise_en), .sck_fall_en(fall_en)
    );

    always @(posedge clk) begin
        if (rise_en)   rc <= rc + 1;
        if (fall_en)   fc <= fc + 1;
        if (slave_rst) kc <= kc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic snap();
        r0 = rc; f0 = fc; k0 = kc;
    endtask

    task automatic sck_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            sck = 1'b1; settle();
            sck = 1'b0; settle();
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        // R9: outputs idle after reset
        check("R9 frozen", frozen, 0);
        check("R9 so_en", so_en, 0);
        check("R9 slave_rst", slave_rst, 0);
        check("R9 pulses", rc + fc + kc, 0);

        // R1: pause with chip select high
        hold_n = 1'b0; settle();
        check("R1 frozen", frozen, 0);
        hold_n = 1'b1; settle();

        // R7: select with pause high enables output
        cs_n = 1'b0; settle();
        check("R7 so_en", so_en, 1);

        // R2: exact latency
        hold_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        check("R2 frozen at edge 2", frozen, 0);
        @(posedge clk); #1;
        check("R2 frozen at edge 3", frozen, 1);
        hold_n = 1'b1; settle();
        check("R4 released", frozen, 0);

        for (int ent_hi = 0; ent_hi < 2; ent_hi++) begin
            for (int ex_hi = 0; ex_hi < 2; ex_hi++) begin
                sck = ent_hi[0]; settle();
                snap();
                hold_n = 1'b0; settle();
                check(ent_hi ? "R3 deferred entry" : "R2 entry", frozen, ent_hi ? 0 : 1);
                if (ent_hi) begin
                    sck = 1'b0; settle();
                    check("R3 entry on sck low", frozen, 1);
                    check("R10 entry edge delivered", fc - f0, 1);
                end
                snap();
                sck_cycles(3);
                check("R5 so_en held", so_en, 0);
                check("R5 rise suppressed", rc - r0, 0);
                check("R5 fall suppressed", fc - f0, 0);
                sck = ex_hi[0]; settle();
                snap();
                hold_n = 1'b1; settle();
                check("R4 release", frozen, ex_hi ? 1 : 0);
                if (ex_hi) begin
                    sck = 1'b0; settle();
                    check("R4 release on sck low", frozen, 0);
                    check("R10 exit edge withheld", fc - f0, 0);
                end
                check("R5 so_en restored", so_en, 1);
                snap();
                sck_cycles(2);
                check("R8 rise count", rc - r0, 2);
                check("R8 fall count", fc - f0, 2);
            end
        end

        // R6: deselect during pause
        hold_n = 1'b0; settle();
        check("R6 paused", frozen, 1);
        snap();
        cs_n = 1'b1; settle();
        check("R6 reset pulses", kc - k0, 1);
        check("R6 frozen cleared", frozen, 0);

        // R7: select with pause still low
        cs_n = 1'b0; settle();
        check("R7 so_en stays off", so_en, 0);
        check("R7 frozen", frozen, 0);
        snap();
        sck_cycles(1);
        check("R7 no edges", (rc - r0) + (fc - f0), 0);
        hold_n = 1'b1; settle();
        check("R7 resumed", so_en, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule